// File: doc/BRIEF.md
# Set-Associative Tag Directory with Reservation Locks

This block keeps the tags of a set-associative cache for line-aligned addresses. Each way stores a tag, a two-bit permission state and an optional lock owner. The lock owner is a requester context number. It backs load-reserve and store-conditional style reservations. Line data, the coherence protocol and statistics live elsewhere.

A controller issues one command per cycle on `cmd_i`, together with an address and the operands that command needs. The response outputs are combinational and are valid in the same cycle. Any state update happens at the next rising clock edge. A command that reports an error leaves every stored bit unchanged, including the replacement order. Each set has an age matrix that keeps the replacement order exactly.

Top module: `tag_dir`

## Requirements
- R1: The set index is `addr_i[OFFSET_W +: SET_W]` and the tag is every address bit above it. The same tag in different sets names different lines. Any command other than NOP with nonzero offset bits raises `err_o`.
- R2: A present hit needs a valid way with a matching tag and a permission other than not-present (0). TEST (2) reports present hits. PEEK (3) reports a tag match whatever the permission. When several ways qualify, the lowest-numbered way is reported.
- R3: ACCESS (1) grants only on a present hit, and only when the permission is read-write (3), or read-only (2) with `req_i` set to load (0) or fetch (1). Invalid (1), and any other request code, is denied.
- R4: A present hit on ACCESS or TEST, and every successful ALLOC, makes that way the most recently used. After reset the victim order of every set is way 0, way 1, and so on upward.
- R5: AVAIL (4) raises `avail_o` when some valid way matches the tag under any permission, or when some way is empty or not-present. `avail_o` is driven for every command.
- R6: ALLOC (5) fills the lowest-numbered empty or not-present way. It sets the permission to invalid (1) and clears the lock.
- R7: DEALLOC (6) empties the present way and clears its lock.
- R8: SETPERM (7) writes `perm_i` into the present way. Any value other than read-write clears the lock. Read-write keeps the lock.
- R9: SETLOCK (8) stores `ctx_i` as the owner of the present way and CLRLOCK (9) removes the owner. TESTLOCK (10) raises `lock_match_o` only when an owner is stored and it equals `ctx_i`.
- R10: PROBE (11) returns on `victim_o` the line address of the victim way: its tag, then the set index, then zero offset bits.
- R11: `err_o` is raised, and no state or order changes, in these cases: ALLOC on a present hit or with no free way; DEALLOC, SETPERM or any lock command without a present hit; PROBE while `avail_o` is high.
- R12: After reset every way is empty with no owner, so every set reports `avail_o` high and no hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 4 | Command code: 0 NOP, 1 ACCESS, 2 TEST, 3 PEEK, 4 AVAIL, 5 ALLOC, 6 DEALLOC, 7 SETPERM, 8 SETLOCK, 9 CLRLOCK, 10 TESTLOCK, 11 PROBE |
| addr_i | input | ADDR_W | Line address |
| req_i | input | 2 | Request type for ACCESS: 0 load, 1 fetch, 2 store |
| perm_i | input | 2 | New permission for SETPERM |
| ctx_i | input | CTX_W | Requester context for lock commands |
| hit_o | output | 1 | Hit (a tag match under any permission for PEEK, a present hit otherwise) |
| hit_way_o | output | WAY_W | Way that hit |
| grant_o | output | 1 | ACCESS granted |
| avail_o | output | 1 | Set can take the address |
| lock_match_o | output | 1 | TESTLOCK owner matches |
| victim_o | output | ADDR_W | Line address of the replacement victim |
| err_o | output | 1 | Command illegal; no state change |

## Verification
On every cycle, the assertions check these properties:
- a grant implies a hit;
- lock commands that miss report an error;
- a present hit implies availability;
- each set's age matrix yields exactly one victim;
- the way written by ALLOC, DEALLOC or SETPERM holds the expected valid, permission and lock bits afterwards.

Victim order after mixed touches needs the bench's sweeps against a recency model. So do the permission-by-request grant table, lock owner comparison over all contexts, and the lowest-way choice when a not-present way is reused.

// File: rtl/tag_dir_pkg.sv
package tag_dir_pkg;
  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_ACCESS   = 4'd1,
    CMD_TEST     = 4'd2,
    CMD_PEEK     = 4'd3,
    CMD_AVAIL    = 4'd4,
    CMD_ALLOC    = 4'd5,
    CMD_DEALLOC  = 4'd6,
    CMD_SETPERM  = 4'd7,
    CMD_SETLOCK  = 4'd8,
    CMD_CLRLOCK  = 4'd9,
    CMD_TESTLOCK = 4'd10,
    CMD_PROBE    = 4'd11
  } cmd_e;

  typedef enum logic [1:0] {
    PERM_NP  = 2'd0,
    PERM_INV = 2'd1,
    PERM_RO  = 2'd2,
    PERM_RW  = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    REQ_LD = 2'd0,
    REQ_IF = 2'd1,
    REQ_ST = 2'd2
  } req_e;
endpackage

// File: rtl/tag_dir_match.sv
module tag_dir_match
  import tag_dir_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][1:0]       perm_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           req_tag_i,
  output logic                       pres_o,
  output logic [WAY_W-1:0]           pres_way_o,
  output logic                       raw_o,
  output logic [WAY_W-1:0]           raw_way_o,
  output logic                       free_o,
  output logic [WAY_W-1:0]           free_way_o
);
  logic [WAYS-1:0] raw_v, pres_v, free_v;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign raw_v[w]  = vld_i[w] && (tag_i[w] == req_tag_i);
    assign pres_v[w] = raw_v[w] && (perm_i[w] != PERM_NP);
    assign free_v[w] = !vld_i[w] || (perm_i[w] == PERM_NP);
  end

  function automatic logic [WAY_W-1:0] lowest(input logic [WAYS-1:0] v);
    lowest = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (v[w]) lowest = WAY_W'(w);
  endfunction

  assign pres_o     = |pres_v;
  assign raw_o      = |raw_v;
  assign free_o     = |free_v;
  assign pres_way_o = lowest(pres_v);
  assign raw_way_o  = lowest(raw_v);
  assign free_way_o = lowest(free_v);
endmodule

// File: rtl/tag_dir_lru.sv
module tag_dir_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] rd_set_i,
  output logic [WAY_W-1:0] victim_way_o,
  output logic [WAYS-1:0]  victim_oh_o
);
  // row i, bit j set: way i used more recently than way j
  logic [WAYS-1:0] age_q [SETS][WAYS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < WAYS; i++)
          for (int j = 0; j < WAYS; j++)
            age_q[s][i][j] <= (i > j);
      end else if (touch_i && touch_set_i == SET_W'(s)) begin
        for (int i = 0; i < WAYS; i++) begin
          if (touch_way_i == WAY_W'(i)) age_q[s][i] <= ~(WAYS'(1) << i);
          else                          age_q[s][i][touch_way_i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    victim_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      victim_oh_o[w] = (age_q[rd_set_i][w] == '0);
    for (int w = WAYS - 1; w >= 0; w--)
      if (victim_oh_o[w]) victim_way_o = WAY_W'(w);
  end
endmodule

// File: rtl/tag_dir.sv
module tag_dir
  import tag_dir_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int OFFSET_W = 2,
  parameter int SETS     = 4,
  parameter int WAYS     = 4,
  parameter int CTX_W    = 3,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int TAG_W   = ADDR_W - OFFSET_W - SET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        req_i,
  input  logic [1:0]        perm_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic              grant_o,
  output logic              avail_o,
  output logic              lock_match_o,
  output logic [ADDR_W-1:0] victim_o,
  output logic              err_o
);
  localparam int IDX_W = SET_W + WAY_W;

  logic [WAYS-1:0]             vld_q  [SETS];
  logic [WAYS-1:0][1:0]        perm_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
  logic [WAYS-1:0]             lkv_q  [SETS];
  logic [WAYS-1:0][CTX_W-1:0]  lkc_q  [SETS];

  cmd_e              cmd;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              misaligned;
  logic              pres_hit, raw_hit, free_any;
  logic [WAY_W-1:0]  pres_way, raw_way, free_way, vic_way;
  logic [WAYS-1:0]   vic_oh;
  logic [1:0]        perm_sel;
  logic              err, touch;
  logic [WAY_W-1:0]  touch_way;

  logic [SETS*WAYS-1:0]      vld_flat, lkv_flat;
  logic [SETS*WAYS-1:0][1:0] perm_flat;

  assign cmd        = cmd_e'(cmd_i);
  assign set_idx    = addr_i[OFFSET_W +: SET_W];
  assign req_tag    = addr_i[ADDR_W-1 -: TAG_W];
  assign misaligned = |addr_i[OFFSET_W-1:0];

  tag_dir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .vld_i     (vld_q[set_idx]),
    .perm_i    (perm_q[set_idx]),
    .tag_i     (tag_q[set_idx]),
    .req_tag_i (req_tag),
    .pres_o    (pres_hit),
    .pres_way_o(pres_way),
    .raw_o     (raw_hit),
    .raw_way_o (raw_way),
    .free_o    (free_any),
    .free_way_o(free_way)
  );

  assign touch_way = (cmd == CMD_ALLOC) ? free_way : pres_way;
  assign touch     = !err && ((cmd == CMD_ALLOC) ||
                     (pres_hit && (cmd == CMD_ACCESS || cmd == CMD_TEST)));

  tag_dir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_set_i (set_idx),
    .touch_way_i (touch_way),
    .rd_set_i    (set_idx),
    .victim_way_o(vic_way),
    .victim_oh_o (vic_oh)
  );

  assign perm_sel = perm_q[set_idx][pres_way];
  assign avail_o  = raw_hit || free_any;

  always_comb begin
    case (cmd)
      CMD_ALLOC:    err = pres_hit || !free_any;
      CMD_DEALLOC, CMD_SETPERM, CMD_SETLOCK,
      CMD_CLRLOCK, CMD_TESTLOCK: err = !pres_hit;
      CMD_PROBE:    err = avail_o;
      default:      err = 1'b0;
    endcase
    if (cmd != CMD_NOP && misaligned) err = 1'b1;
  end

  assign err_o        = err;
  assign hit_o        = (cmd == CMD_PEEK) ? raw_hit : pres_hit;
  assign hit_way_o    = (cmd == CMD_PEEK) ? raw_way : pres_way;
  assign grant_o      = (cmd == CMD_ACCESS) && pres_hit &&
                        (perm_sel == PERM_RW ||
                         (perm_sel == PERM_RO && (req_i == REQ_LD || req_i == REQ_IF)));
  assign lock_match_o = (cmd == CMD_TESTLOCK) && pres_hit &&
                        lkv_q[set_idx][pres_way] && (lkc_q[set_idx][pres_way] == ctx_i);
  assign victim_o     = {tag_q[set_idx][vic_way], set_idx, {OFFSET_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        perm_q[s] <= '0;
        tag_q[s]  <= '0;
        lkv_q[s]  <= '0;
        lkc_q[s]  <= '0;
      end
    end else if (!err) begin
      case (cmd)
        CMD_ALLOC: begin
          vld_q[set_idx][free_way]  <= 1'b1;
          tag_q[set_idx][free_way]  <= req_tag;
          perm_q[set_idx][free_way] <= PERM_INV;
          lkv_q[set_idx][free_way]  <= 1'b0;
        end
        CMD_DEALLOC: begin
          vld_q[set_idx][pres_way] <= 1'b0;
          lkv_q[set_idx][pres_way] <= 1'b0;
        end
        CMD_SETPERM: begin
          perm_q[set_idx][pres_way] <= perm_i;
          if (perm_i != PERM_RW) lkv_q[set_idx][pres_way] <= 1'b0;
        end
        CMD_SETLOCK: begin
          lkv_q[set_idx][pres_way] <= 1'b1;
          lkc_q[set_idx][pres_way] <= ctx_i;
        end
        CMD_CLRLOCK: lkv_q[set_idx][pres_way] <= 1'b0;
        default: ;
      endcase
    end
  end

  // flattened views for the checker
  for (genvar s = 0; s < SETS; s++) begin : g_flat
    for (genvar w = 0; w < WAYS; w++) begin : g_w
      assign vld_flat[s*WAYS+w]  = vld_q[s][w];
      assign lkv_flat[s*WAYS+w]  = lkv_q[s][w];
      assign perm_flat[s*WAYS+w] = perm_q[s][w];
    end
  end

  logic [IDX_W-1:0] unused_idx;
  assign unused_idx = {set_idx, pres_way};
endmodule

// File: rtl/tag_dir_chk.sv
module tag_dir_chk
  import tag_dir_pkg::*;
#(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = SET_W + WAY_W
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [3:0]                cmd_i,
  input logic [1:0]                perm_i,
  input logic                      err_o,
  input logic                      hit_o,
  input logic                      grant_o,
  input logic                      avail_o,
  input logic [SET_W-1:0]          set_idx,
  input logic [WAY_W-1:0]          pres_way,
  input logic [WAY_W-1:0]          free_way,
  input logic                      pres_hit,
  input logic [WAYS-1:0]           vic_oh,
  input logic [SETS*WAYS-1:0]      vld_flat,
  input logic [SETS*WAYS-1:0]      lkv_flat,
  input logic [SETS*WAYS-1:0][1:0] perm_flat
);
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic             lock_cmd;
  assign hit_idx  = {set_idx, pres_way};
  assign free_idx = {set_idx, free_way};
  assign lock_cmd = (cmd_i == CMD_SETLOCK) || (cmd_i == CMD_CLRLOCK) ||
                    (cmd_i == CMD_TESTLOCK);

  p_grant_needs_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> hit_o);

  p_lock_miss_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_cmd && !pres_hit) |-> err_o);

  p_hit_is_avail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pres_hit |-> avail_o);

  p_one_victim_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(vic_oh) == 1);

  p_alloc_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ALLOC && !err_o) |=>
      (vld_flat[$past(free_idx)] && perm_flat[$past(free_idx)] == PERM_INV &&
       !lkv_flat[$past(free_idx)]));

  p_dealloc_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_DEALLOC && !err_o) |=>
      (!vld_flat[$past(hit_idx)] && !lkv_flat[$past(hit_idx)]));

  p_downgrade_unlock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_SETPERM && !err_o && perm_i != PERM_RW) |=>
      !lkv_flat[$past(hit_idx)]);

  p_rw_keeps_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_SETPERM && !err_o && perm_i == PERM_RW) |=>
      (lkv_flat[$past(hit_idx)] == $past(lkv_flat[hit_idx])));
endmodule

bind tag_dir tag_dir_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cmd_i    (cmd_i),
  .perm_i   (perm_i),
  .err_o    (err_o),
  .hit_o    (hit_o),
  .grant_o  (grant_o),
  .avail_o  (avail_o),
  .set_idx  (set_idx),
  .pres_way (pres_way),
  .free_way (free_way),
  .pres_hit (pres_hit),
  .vic_oh   (vic_oh),
  .vld_flat (vld_flat),
  .lkv_flat (lkv_flat),
  .perm_flat(perm_flat)
);

// File: tb/tag_dir_bench.sv
module tag_dir_bench;
  import tag_dir_pkg::*;

  localparam int CLK_P    = 10;
  localparam int ADDR_W   = 12;
  localparam int OFFSET_W = 2;
  localparam int SETS     = 4;
  localparam int WAYS     = 4;
  localparam int CTX_W    = 3;
  localparam int WAY_W    = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [3:0]        cmd_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [1:0]        req_i = '0;
  logic [1:0]        perm_i = '0;
  logic [CTX_W-1:0]  ctx_i = '0;
  logic              hit_o, grant_o, avail_o, lock_match_o, err_o;
  logic [WAY_W-1:0]  hit_way_o;
  logic [ADDR_W-1:0] victim_o;

  always #(CLK_P/2) clk = ~clk;

  tag_dir #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS), .WAYS(WAYS),
            .CTX_W(CTX_W)) u_tag_dir (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .addr_i(addr_i),
    .req_i(req_i), .perm_i(perm_i), .ctx_i(ctx_i), .hit_o(hit_o),
    .hit_way_o(hit_way_o), .grant_o(grant_o), .avail_o(avail_o),
    .lock_match_o(lock_match_o), .victim_o(victim_o), .err_o(err_o)
  );

  // reference model
  bit m_vld [SETS][WAYS];
  int m_perm[SETS][WAYS];
  int m_tag [SETS][WAYS];
  bit m_lkv [SETS][WAYS];
  int m_lkc [SETS][WAYS];
  int m_age [SETS][WAYS];
  int age_ctr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int mk(int t, int s);
    return (t << 4) | (s << 2);
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic op(int c, int a, int r = 0, int p = 0, int x = 0, string ovr = "");
    int s, t, pw, rw, fw, vw, exp_hit, exp_way, exp_grant, exp_lm, exp_av;
    bit ph, rh, fa, e;
    string rq;
    @(negedge clk);
    cmd_i = 4'(c); addr_i = ADDR_W'(a); req_i = 2'(r); perm_i = 2'(p); ctx_i = CTX_W'(x);
    #1;
    s = (a >> 2) & 3; t = (a >> 4) & 255;
    ph = 0; rh = 0; fa = 0; pw = 0; rw = 0; fw = 0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (m_vld[s][w] && m_tag[s][w] == t) begin
        rh = 1; rw = w;
      end
      if (m_vld[s][w] && m_tag[s][w] == t && m_perm[s][w] != 0) begin
        ph = 1; pw = w;
      end
      if (!m_vld[s][w] || m_perm[s][w] == 0) begin
        fa = 1; fw = w;
      end
    end
    vw = 0;
    for (int w = 1; w < WAYS; w++) if (m_age[s][w] < m_age[s][vw]) vw = w;
    exp_hit   = (c == CMD_PEEK) ? rh : ph;
    exp_way   = (c == CMD_PEEK) ? rw : pw;
    exp_av    = rh || fa;
    exp_grant = (c == CMD_ACCESS) && ph &&
                (m_perm[s][pw] == 3 || (m_perm[s][pw] == 2 && r < 2));
    exp_lm    = (c == CMD_TESTLOCK) && ph && m_lkv[s][pw] && m_lkc[s][pw] == x;
    case (c)
      CMD_ALLOC: e = ph || !fa;
      CMD_DEALLOC, CMD_SETPERM, CMD_SETLOCK, CMD_CLRLOCK, CMD_TESTLOCK: e = !ph;
      CMD_PROBE: e = exp_av;
      default: e = 0;
    endcase
    if (c != 0 && (a & 3) != 0) e = 1;
    case (c)
      CMD_ACCESS: rq = "R3";
      CMD_TEST, CMD_PEEK: rq = "R2";
      CMD_AVAIL: rq = "R5";
      CMD_ALLOC: rq = "R6";
      CMD_DEALLOC: rq = "R7";
      CMD_SETPERM: rq = "R8";
      CMD_PROBE: rq = "R10";
      default: rq = "R9";
    endcase
    if (ovr != "") rq = ovr;
    chk(rq, "hit", int'(hit_o), exp_hit);
    if (exp_hit != 0) chk(rq, "hit_way", int'(hit_way_o), exp_way);
    chk("R3", "grant", int'(grant_o), exp_grant);
    chk("R5", "avail", int'(avail_o), exp_av);
    chk("R9", "lock_match", int'(lock_match_o), exp_lm);
    chk(e ? "R11" : rq, "err", int'(err_o), int'(e));
    if (c == CMD_PROBE && !e) chk("R4 R10", "victim", int'(victim_o), mk(m_tag[s][vw], s));
    @(posedge clk);
    if (!e) begin
      case (c)
        CMD_ACCESS, CMD_TEST: if (ph) m_age[s][pw] = age_ctr++;
        CMD_ALLOC: begin
          m_vld[s][fw] = 1; m_tag[s][fw] = t; m_perm[s][fw] = 1; m_lkv[s][fw] = 0;
          m_age[s][fw] = age_ctr++;
        end
        CMD_DEALLOC: begin m_vld[s][pw] = 0; m_lkv[s][pw] = 0; end
        CMD_SETPERM: begin m_perm[s][pw] = p; if (p != 3) m_lkv[s][pw] = 0; end
        CMD_SETLOCK: begin m_lkv[s][pw] = 1; m_lkc[s][pw] = x; end
        CMD_CLRLOCK: m_lkv[s][pw] = 0;
        default: ;
      endcase
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0; m_perm[s][w] = 0; m_tag[s][w] = 0;
        m_lkv[s][w] = 0; m_lkc[s][w] = 0; m_age[s][w] = w;
      end
    age_ctr = WAYS;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R12: empty after reset
    for (int s = 0; s < SETS; s++) begin
      op(CMD_AVAIL, mk(9, s), 0, 0, 0, "R12");
      op(CMD_TEST, mk(9, s), 0, 0, 0, "R12");
      op(CMD_PROBE, mk(9, s), 0, 0, 0, "R12");
    end
    // R6 / R1: fill every set with the same tags
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) op(CMD_ALLOC, mk(w + 1, s));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        op(CMD_TEST, mk(w + 1, s), 0, 0, 0, "R1");
        op(CMD_TEST, mk(w + 1, s) | 3, 0, 0, 0, "R1");
      end
    // R11: full set, duplicate allocation
    op(CMD_AVAIL, mk(7, 0));
    op(CMD_ALLOC, mk(7, 0));
    op(CMD_ALLOC, mk(2, 0));
    // R4: reset order then touch patterns
    for (int s = 0; s < SETS; s++) op(CMD_PROBE, mk(7, s), 0, 0, 0, "R4");
    op(CMD_TEST, mk(1, 0)); op(CMD_TEST, mk(3, 0)); op(CMD_PROBE, mk(7, 0));
    op(CMD_ACCESS, mk(2, 0), 0); op(CMD_PROBE, mk(7, 0));
    op(CMD_PEEK, mk(4, 0)); op(CMD_PROBE, mk(7, 0), 0, 0, 0, "R4");
    // R3: permission x request sweep
    for (int p = 1; p < 4; p++)
      for (int r = 0; r < 4; r++) begin
        op(CMD_SETPERM, mk(2, 1), 0, p);
        op(CMD_ACCESS, mk(2, 1), r);
      end
    // R9 / R8: locks
    op(CMD_SETLOCK, mk(1, 2), 0, 0, 5);
    for (int x = 0; x < 8; x++) op(CMD_TESTLOCK, mk(1, 2), 0, 0, x);
    op(CMD_SETPERM, mk(1, 2), 0, 3); op(CMD_TESTLOCK, mk(1, 2), 0, 0, 5);
    op(CMD_SETPERM, mk(1, 2), 0, 3); op(CMD_TESTLOCK, mk(1, 2), 0, 0, 5);
    op(CMD_SETPERM, mk(1, 2), 0, 2); op(CMD_TESTLOCK, mk(1, 2), 0, 0, 5);
    op(CMD_SETLOCK, mk(1, 2), 0, 0, 3); op(CMD_CLRLOCK, mk(1, 2));
    op(CMD_TESTLOCK, mk(1, 2), 0, 0, 3);
    op(CMD_SETLOCK, mk(9, 2), 0, 0, 1); op(CMD_TESTLOCK, mk(9, 2), 0, 0, 1);
    op(CMD_CLRLOCK, mk(9, 2));
    // R2: not-present way
    op(CMD_SETPERM, mk(2, 3), 0, 0);
    op(CMD_TEST, mk(2, 3)); op(CMD_PEEK, mk(2, 3));
    op(CMD_AVAIL, mk(9, 3)); op(CMD_AVAIL, mk(2, 3));
    op(CMD_ALLOC, mk(9, 3)); op(CMD_TEST, mk(9, 3));
    // R7: deallocate clears lock
    op(CMD_SETLOCK, mk(3, 2), 0, 0, 6); op(CMD_DEALLOC, mk(3, 2));
    op(CMD_TESTLOCK, mk(3, 2), 0, 0, 6); op(CMD_AVAIL, mk(8, 2));
    op(CMD_ALLOC, mk(3, 2)); op(CMD_TESTLOCK, mk(3, 2), 0, 0, 6);
    op(CMD_DEALLOC, mk(8, 2));
    // mixed sweep against the model
    for (int i = 0; i < 3000; i++) begin
      int a;
      a = mk(1 + $urandom_range(5), $urandom_range(3));
      if ($urandom_range(24) == 0) a = a | 1;
      op(1 + $urandom_range(10), a, $urandom_range(3), $urandom_range(3), $urandom_range(7));
    end
    summary();
  end
endmodule